// File: doc/BRIEF.md
# Reset and Low-Power Sequencer

This block sequences the reset of a codec front-end's digital core. It runs on the free-running oscillator clock and combines two reset sources: an asynchronous power-on reset and an active-low pin. The same pin acts as a hard reset at start-up and, during normal running, as the control for low-power mode. It drives separate reset strobes for the phase-locked loop, the clock-generator counters and the control registers. It also drives an oscillator enable, an analog power-down flag and a serial-access enable.

The block holds the transmit attenuator code. At power-on this code is loaded with its infinite-attenuation value, so that nothing reaches the line until software writes a real setting. While the pin is low, the loop and the counters stay in reset, the analog section is powered down and the oscillator is stopped. When the pin is released, the block waits for a fixed run of consecutive oscillator cycles before it reopens serial access. The analog power-down flag clears as soon as the synchronized pin is seen high, which is well before access returns.

Top module: `lpr_ctrl`

## Requirements
- R1: While `por_n` is low, the outputs are: `dpll_rst`=1, `clkgen_rst`=1, `ctrl_rst`=1, `osc_en`=0, `analog_pd`=1, `serial_en`=0, and `tx_atten` all ones. The all-ones code is the infinite-attenuation setting.
- R2: `ctrl_rst` goes low on the first clock edge after `por_n` rises. It stays low until the next power-on reset.
- R3: The pin passes through SYNC_STAGES flops before use. A change on `lp_n` reaches `osc_en`, `analog_pd`, `dpll_rst` and `clkgen_rst` on exactly the SYNC_STAGES-th rising edge after the change.
- R4: While the synchronized pin is low, `dpll_rst`=1, `clkgen_rst`=1, `osc_en`=0 and `analog_pd`=1.
- R5: `serial_en` rises on exactly the (SYNC_STAGES+START_CYCLES)-th rising edge after `lp_n` goes high, provided the pin stays high throughout.
- R6: A low on the synchronized pin drops `serial_en` on the same edge, clears the start-up count, and restarts the full START_CYCLES wait after the next release.
- R7: `analog_pd` clears START_CYCLES edges before `serial_en` rises, and `analog_pd` and `serial_en` are never high together.
- R8: A write (`atten_wr`=1) while `serial_en`=1 loads `atten_wdata` into `tx_atten`. The new value is visible after that rising edge.
- R9: A write while `serial_en`=0 is ignored, and `tx_atten` keeps its value.
- R10: Entering or leaving low-power mode through the pin does not change `tx_atten`.
- R11: `por_n` going low takes effect at once, without a clock edge, and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lp_n | input | 1 | Low-power/reset pin, active low, asynchronous |
| atten_wr | input | 1 | Write strobe for the attenuator control register |
| atten_wdata | input | ATT_W | Attenuator code to write |
| dpll_rst | output | 1 | Reset to the phase-locked loop |
| clkgen_rst | output | 1 | Reset to the symbol, bit and sampling clock counters |
| ctrl_rst | output | 1 | Reset to the control registers (power-on only) |
| osc_en | output | 1 | Oscillator enable |
| analog_pd | output | 1 | Analog power-down flag |
| serial_en | output | 1 | Serial-interface access enable |
| tx_atten | output | ATT_W | Transmit attenuator code |

## Verification
The bench goes after the exact edge on which access returns, sampling one edge early and one edge on time. A design whose counter is off by one, or that counts from the raw pin instead of the synchronized one, shows up on one of these two samples. A single-cycle low pulse in the middle of the wake-up wait must restart the count. A design that only pauses the count, or ignores the pulse, would grant access early. Writes made before access is granted must leave the infinite-attenuation code in place, and a low-power cycle must keep the written code. A design that resets the attenuator on the pin, or accepts early writes, would show the wrong code. A mid-run power-on reset is checked without waiting for a clock edge, which catches a reset made synchronous by mistake.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
   typedef enum logic [1:0] {
      PH_SLEEP  = 2'd0,
      PH_WAKING = 2'd1,
      PH_RUN    = 2'd2
   } lpr_phase_e;

   function automatic logic phase_holds_core(input lpr_phase_e ph);
      return ph == PH_SLEEP;
   endfunction
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("lpr_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], d_async};
   end

   assign q_sync = chain[SYNC_STAGES-1];
endmodule

// File: rtl/lpr_start_timer.sv
module lpr_start_timer #(
   parameter int START_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(START_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(START_CYCLES);

   generate
      if (START_CYCLES < 1) begin : g_bad_start
         $error("lpr_start_timer: START_CYCLES must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LIMIT);

   a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIMIT);
   a_r6_restart_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);
   a_r5_full_wait: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(cnt) == LIMIT - 1'b1);
endmodule

// File: rtl/lpr_atten_reg.sv
module lpr_atten_reg #(
   parameter int ATT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic             wr_ok,
   input  logic [ATT_W-1:0] wdata,
   output logic [ATT_W-1:0] q
);
   localparam logic [ATT_W-1:0] INF_CODE = '1;

   generate
      if (ATT_W < 1) begin : g_bad_width
         $error("lpr_atten_reg: ATT_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= INF_CODE;
      else if (clr)        q <= INF_CODE;
      else if (wr && wr_ok) q <= wdata;
   end

   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wr_ok && !clr) |=> q == $past(wdata));
   a_r9_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> $stable(q));
endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl #(
   parameter int SYNC_STAGES  = 2,
   parameter int START_CYCLES = 1024,
   parameter int ATT_W        = 6
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             lp_n,
   input  logic             atten_wr,
   input  logic [ATT_W-1:0] atten_wdata,
   output logic             dpll_rst,
   output logic             clkgen_rst,
   output logic             ctrl_rst,
   output logic             osc_en,
   output logic             analog_pd,
   output logic             serial_en,
   output logic [ATT_W-1:0] tx_atten
);
   import lpr_pkg::*;

   logic       pin_s;
   logic       start_done;
   logic       ctrl_rst_q;
   lpr_phase_e phase;

   lpr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (por_n),
      .d_async (lp_n),
      .q_sync  (pin_s)
   );

   lpr_start_timer #(.START_CYCLES(START_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (por_n),
      .run   (pin_s),
      .done  (start_done)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) ctrl_rst_q <= 1'b1;
      else        ctrl_rst_q <= 1'b0;
   end

   always_comb begin
      if (!pin_s)          phase = PH_SLEEP;
      else if (!start_done) phase = PH_WAKING;
      else                 phase = PH_RUN;
   end

   assign dpll_rst   = phase_holds_core(phase);
   assign clkgen_rst = phase_holds_core(phase);
   assign osc_en     = phase != PH_SLEEP;
   assign analog_pd  = phase == PH_SLEEP;
   assign serial_en  = phase == PH_RUN;
   assign ctrl_rst   = ctrl_rst_q;

   lpr_atten_reg #(.ATT_W(ATT_W)) u_atten (
      .clk   (clk),
      .rst_n (por_n),
      .clr   (ctrl_rst_q),
      .wr    (atten_wr),
      .wr_ok (serial_en),
      .wdata (atten_wdata),
      .q     (tx_atten)
   );

   a_r7_pd_excludes_access: assert property (@(posedge clk) disable iff (!por_n)
      !(analog_pd && serial_en));
   a_r4_core_held_in_sleep: assert property (@(posedge clk) disable iff (!por_n)
      !osc_en |-> (dpll_rst && clkgen_rst && !serial_en));
   a_r2_ctrl_rst_once: assert property (@(posedge clk) disable iff (!por_n)
      !ctrl_rst |=> !ctrl_rst);
   a_r6_access_needs_osc: assert property (@(posedge clk) disable iff (!por_n)
      $fell(osc_en) |-> !serial_en);
endmodule

// File: tb/lpr_ctrl_test.sv
module lpr_ctrl_test;
   localparam int CLK_P = 10;
   localparam int SYNC  = 2;
   localparam int START = 1024;
   localparam int AW    = 6;
   localparam logic [AW-1:0] ONES = '1;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic lp_n = 1'b0;
   logic atten_wr = 1'b0;
   logic [AW-1:0] atten_wdata = '0;
   logic dpll_rst, clkgen_rst, ctrl_rst, osc_en, analog_pd, serial_en;
   logic [AW-1:0] tx_atten;
   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   lpr_ctrl #(.SYNC_STAGES(SYNC), .START_CYCLES(START), .ATT_W(AW)) uut (
      .clk(clk), .por_n(por_n), .lp_n(lp_n), .atten_wr(atten_wr),
      .atten_wdata(atten_wdata), .dpll_rst(dpll_rst), .clkgen_rst(clkgen_rst),
      .ctrl_rst(ctrl_rst), .osc_en(osc_en), .analog_pd(analog_pd),
      .serial_en(serial_en), .tx_atten(tx_atten)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_atten(input logic [AW-1:0] v);
      atten_wr = 1'b1; atten_wdata = v;
      step(1);
      atten_wr = 1'b0;
   endtask

   task automatic t_por_state;
      por_n = 1'b0; lp_n = 1'b0;
      step(3);
      chk("R1 dpll_rst", dpll_rst, 1);
      chk("R1 clkgen_rst", clkgen_rst, 1);
      chk("R1 ctrl_rst", ctrl_rst, 1);
      chk("R1 osc_en", osc_en, 0);
      chk("R1 analog_pd", analog_pd, 1);
      chk("R1 serial_en", serial_en, 0);
      chk("R1 tx_atten", tx_atten, ONES);
      por_n = 1'b1;
      step(1);
      chk("R2 ctrl_rst released", ctrl_rst, 0);
      step(5);
      chk("R2 ctrl_rst stays low", ctrl_rst, 0);
   endtask

   task automatic t_early_write;
      write_atten(6'h15);
      chk("R9 write before access ignored", tx_atten, ONES);
      chk("R4 dpll_rst held in sleep", dpll_rst, 1);
   endtask

   task automatic t_wake;
      lp_n = 1'b1;
      step(SYNC - 1);
      chk("R3 analog_pd one edge early", analog_pd, 1);
      chk("R3 osc_en one edge early", osc_en, 0);
      step(1);
      chk("R3 analog_pd cleared", analog_pd, 0);
      chk("R3 osc_en set", osc_en, 1);
      chk("R3 dpll_rst released", dpll_rst, 0);
      chk("R3 clkgen_rst released", clkgen_rst, 0);
      chk("R7 access still closed", serial_en, 0);
      write_atten(6'h0A);
      chk("R9 write while waking ignored", tx_atten, ONES);
      step(START - 2);
      chk("R5 serial_en one edge early", serial_en, 0);
      step(1);
      chk("R5 serial_en on time", serial_en, 1);
   endtask

   task automatic t_write;
      write_atten(6'h2C);
      chk("R8 write accepted", tx_atten, 6'h2C);
      write_atten(6'h03);
      chk("R8 second write", tx_atten, 6'h03);
   endtask

   task automatic t_sleep;
      lp_n = 1'b0;
      step(SYNC - 1);
      chk("R6 access before sync", serial_en, 1);
      step(1);
      chk("R6 access dropped", serial_en, 0);
      chk("R4 analog_pd", analog_pd, 1);
      chk("R4 osc_en", osc_en, 0);
      chk("R4 clkgen_rst", clkgen_rst, 1);
      chk("R10 atten kept in sleep", tx_atten, 6'h03);
      step(20);
      chk("R10 atten kept after long sleep", tx_atten, 6'h03);
   endtask

   task automatic t_glitch;
      lp_n = 1'b1;
      step(500);
      chk("R6 waking mid-count", serial_en, 0);
      lp_n = 1'b0;
      step(1);
      lp_n = 1'b1;
      step(SYNC + START - 1);
      chk("R6 count restarted", serial_en, 0);
      step(1);
      chk("R6 access after full restart", serial_en, 1);
      chk("R10 atten kept after wake", tx_atten, 6'h03);
   endtask

   task automatic t_async_por;
      #1;
      por_n = 1'b0;
      #1;
      chk("R11 serial_en async", serial_en, 0);
      chk("R11 tx_atten async", tx_atten, ONES);
      chk("R11 ctrl_rst async", ctrl_rst, 1);
      chk("R11 dpll_rst async", dpll_rst, 1);
      step(2);
      por_n = 1'b1;
      step(2);
   endtask

   initial begin
      step(1);
      t_por_state();
      t_early_write();
      t_wake();
      t_write();
      t_sleep();
      t_glitch();
      t_async_por();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule